// File: doc/BRIEF.md
# Shared-Period Multi-Channel PWM Timer

This block produces several pulse-width-modulated outputs from a single 16-bit up-counter. The counter advances on tick enables from a 7-bit prescaler. It wraps to zero when it reaches the programmed period. Every wrap is a period event, and that event drives each enabled output high. Each channel has its own compare value. When the counter reaches that value, a channel event drives the output low again. Because all channels share one counter, their rising edges are aligned and only their pulse widths differ.

Software programs the timer through a single-cycle write port. The port loads the period, the per-channel compares, the channel enables and a control word. The control word carries the prescaler divide value, a halt bit and a counter-clear bit. Writes to the period and to the compares go into holding (shadow) registers. The live values take those contents only at a counter wrap, so a period in progress is never cut short or stretched.

The count is also visible on an output port, so a system can line other activity up with the PWM frame.

Top module: `shared_pwm_timer`

## Requirements
- R1: After a synchronous active-low reset:
  - the count is 0 and all outputs are low;
  - the period (live and shadow) is 20000 ticks and every compare is 0;
  - the prescaler divide field is 0, the counter is running and every channel is disabled.
- R2: Control register bits [11:5] hold a divide value D. The counter advances by one once every D+1 clock cycles while it runs, and holds its value between advances.
- R3: With a live period P (written at address 0), the count runs 0, 1, ..., P-1 and then returns to 0 on the next advance. If P is 0 or 1, the count stays at 0 and every advance is a wrap.
- R4: A write to the period (address 0) or to a compare (address n+1 for channel n) changes only the shadow value. The live value takes the shadow content at the next wrap. A write on the same edge as a wrap takes effect one wrap later.
- R5: An enabled channel output rises on a wrap. It falls when the counter reaches that channel's live compare C. Over each full period it is therefore high exactly while the count is below C, and it rises at no other time.
- R6: A compare of 0 keeps the output low for the whole period: the clear event wins over the set event. A compare at or above the period keeps the output high for the whole period.
- R7: While control bit 2 (halt) is 1, the counter and the prescaler hold their values and no events occur.
- R8: A control write with bit 3 set forces the count and the prescaler to 0 on that edge. This raises no event and leaves the outputs and live values unchanged. The bit is not stored, so counting resumes on the following cycles.
- R9: Enable register bit n (address 6) enables channel n. A disabled channel's output is low from the cycle after the write. A channel enabled in mid-period stays low until the next wrap.
- R10: Address 5 holds the control register. Address 7 is unused, and a write there changes neither the count nor any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 3 | Register address (0 period, 1-4 compares, 5 control, 6 enables) |
| wr_data | input | 16 | Write data |
| pwm_o | output | 4 | PWM outputs, bit n is channel n |
| count_o | output | 16 | Current counter value |

## Verification
The hardest situation to reach is a shadow write that lands on the very edge where the counter wraps, together with a period change that leaves old compares above or below the new period. From the ports this takes exact cycle alignment. The reset period of 20000 ticks also makes the first reload slow. The stimulus therefore waits through one full long period, then moves to periods of at most 12 ticks. It follows with bursts of random writes at random gaps with a small prescaler, so writes fall on wrap edges, on halted cycles and on clear cycles many times. A cycle-by-cycle bench model compares the count and all outputs on every cycle.

// File: rtl/shared_pwm_pkg.sv
// Package: shared constants for the shared-period PWM timer.
// Assumes the control word is at least PSC_LSB + prescaler width bits wide.
package shared_pwm_pkg;
    localparam int HALT_BIT = 2;   // control: counter halt
    localparam int CLR_BIT  = 3;   // control: counter clear (pulse, not stored)
    localparam int PSC_LSB  = 5;   // control: lowest bit of the divide field

    // Address of the control register for a given channel count.
    function automatic int ctrl_addr(input int nch);
        return nch + 1;
    endfunction

    // Address of the channel enable register for a given channel count.
    function automatic int ena_addr(input int nch);
        return nch + 2;
    endfunction
endpackage

// File: rtl/spt_prescaler.sv
// Prescaler: emits a one-cycle tick every (div+1) clocks while run is high.
// Assumes div may change at any time; a count already at or past div ticks at once.
module spt_prescaler #(
    parameter int PSW = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic           clr,
    input  logic [PSW-1:0] div,
    output logic           tick
);
    logic [PSW-1:0] pcnt;

    // Tick when the divide count is reached and the timer runs.
    assign tick = run && !clr && (pcnt >= div);

    // Divide counter: cleared on clear or tick, held while halted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt <= '0;
        end else if (clr || tick) begin
            pcnt <= '0;
        end else if (run) begin
            pcnt <= pcnt + 1'b1;
        end
    end
endmodule

// File: rtl/spt_counter.sv
// Shared period counter: counts ticks and wraps at the live period.
// Holds the period shadow register and loads it into the live period on wrap.
// Assumes tick is never high in a cycle where clr is high.
module spt_counter #(
    parameter int CW         = 16,
    parameter int RST_PERIOD = 20000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          clr,
    input  logic          per_wr,
    input  logic [CW-1:0] per_wdata,
    output logic [CW-1:0] cnt,
    output logic          wrap
);
    localparam logic [CW-1:0] PER_INIT = CW'(RST_PERIOD);

    logic [CW-1:0] per_shd;
    logic [CW-1:0] per_act;
    logic [CW:0]   cnt_inc;

    // Next count, one bit wider so the period match cannot overflow.
    assign cnt_inc = {1'b0, cnt} + {{CW{1'b0}}, 1'b1};
    // Wrap when the next count would reach the period.
    assign wrap    = tick && (cnt_inc >= {1'b0, per_act});

    // Period shadow: written by software only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_shd <= PER_INIT;
        end else if (per_wr) begin
            per_shd <= per_wdata;
        end
    end

    // Live period: reloaded from the shadow on a wrap only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_act <= PER_INIT;
        end else if (wrap) begin
            per_act <= per_shd;
        end
    end

    // Counter: clear, wrap to zero, or step on tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr || wrap) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt_inc[CW-1:0];
        end
    end
endmodule

// File: rtl/spt_channel.sv
// One PWM channel: compare shadow and live registers plus an event-driven output.
// Output is set on wrap (unless the new compare is 0) and cleared when the
// counter reaches the live compare. Assumes cnt and wrap come from spt_counter.
module spt_channel #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmp_wr,
    input  logic [CW-1:0] cmp_wdata,
    input  logic          en,
    input  logic          tick,
    input  logic          wrap,
    input  logic [CW-1:0] cnt,
    output logic          pwm
);
    logic [CW-1:0] cmp_shd;
    logic [CW-1:0] cmp_act;
    logic [CW-1:0] cnt_nx;
    logic          out_q;

    // Count value the counter takes on a non-wrapping tick.
    assign cnt_nx = cnt + CW'(1);
    // Disabled channels drive low at once.
    assign pwm    = out_q & en;

    // Compare shadow: written by software only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_shd <= '0;
        end else if (cmp_wr) begin
            cmp_shd <= cmp_wdata;
        end
    end

    // Live compare: reloaded from the shadow on a wrap only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_act <= '0;
        end else if (wrap) begin
            cmp_act <= cmp_shd;
        end
    end

    // Output state: set event on wrap, clear event on compare match.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            out_q <= 1'b0;
        end else if (wrap) begin
            out_q <= (cmp_shd != '0);
        end else if (tick && (cnt_nx == cmp_act)) begin
            out_q <= 1'b0;
        end
    end
endmodule

// File: rtl/shared_pwm_timer.sv
// Top: shared-period PWM timer with NCH channels.
// Decodes the write port, keeps the control and enable registers, and ties the
// prescaler, the shared counter and the channels together.
// Assumes CW >= PSC_LSB + PSW and CW >= NCH.
module shared_pwm_timer
    import shared_pwm_pkg::*;
#(
    parameter int NCH        = 4,
    parameter int CW         = 16,
    parameter int PSW        = 7,
    parameter int RST_PERIOD = 20000,
    localparam int AW        = $clog2(NCH + 3)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [CW-1:0]  wr_data,
    output logic [NCH-1:0] pwm_o,
    output logic [CW-1:0]  count_o
);
    localparam logic [AW-1:0] A_PER  = AW'(0);
    localparam logic [AW-1:0] A_CTRL = AW'(ctrl_addr(NCH));
    localparam logic [AW-1:0] A_ENA  = AW'(ena_addr(NCH));

    logic           halt_q;
    logic [PSW-1:0] psc_q;
    logic [NCH-1:0] en_q;
    logic           wr_ctrl;
    logic           wr_ena;
    logic           wr_per;
    logic           clr_pulse;
    logic           tick;
    logic           wrap;
    logic [CW-1:0]  cnt;

    // Write decode for the shared registers.
    assign wr_per    = wr_en && (wr_addr == A_PER);
    assign wr_ctrl   = wr_en && (wr_addr == A_CTRL);
    assign wr_ena    = wr_en && (wr_addr == A_ENA);
    assign clr_pulse = wr_ctrl && wr_data[CLR_BIT];
    assign count_o   = cnt;

    // Control and enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt_q <= 1'b0;
            psc_q  <= '0;
            en_q   <= '0;
        end else begin
            if (wr_ctrl) begin
                halt_q <= wr_data[HALT_BIT];
                psc_q  <= wr_data[PSC_LSB +: PSW];
            end
            if (wr_ena) begin
                en_q <= wr_data[NCH-1:0];
            end
        end
    end

    spt_prescaler #(.PSW(PSW)) u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (!halt_q),
        .clr   (clr_pulse),
        .div   (psc_q),
        .tick  (tick)
    );

    spt_counter #(.CW(CW), .RST_PERIOD(RST_PERIOD)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .clr       (clr_pulse),
        .per_wr    (wr_per),
        .per_wdata (wr_data),
        .cnt       (cnt),
        .wrap      (wrap)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic cmp_wr;
        // Channel i compare lives at address i+1.
        assign cmp_wr = wr_en && (wr_addr == AW'(i + 1));

        spt_channel #(.CW(CW)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .cmp_wr    (cmp_wr),
            .cmp_wdata (wr_data),
            .en        (en_q[i]),
            .tick      (tick),
            .wrap      (wrap),
            .cnt       (cnt),
            .pwm       (pwm_o[i])
        );
    end
endmodule

// File: rtl/shared_pwm_timer_chk.sv
// Checker for shared_pwm_timer: timing properties of counter and outputs.
// Attached to every instance of the top through the bind below.
module shared_pwm_timer_chk #(
    parameter int NCH = 4,
    parameter int CW  = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic           halt_q,
    input logic           clr_pulse,
    input logic           tick,
    input logic           wrap,
    input logic [CW-1:0]  cnt,
    input logic [NCH-1:0] en_q,
    input logic [NCH-1:0] pwm_o
);
    // A wrap returns the counter to zero.
    p_wrap_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt == '0));

    // A non-wrapping tick steps the counter by one.
    p_tick_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wrap) |=> (cnt == $past(cnt) + CW'(1)));

    // Without tick or clear the counter holds.
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr_pulse) |=> $stable(cnt));

    // Halt freezes the counter.
    p_halt_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_q && !clr_pulse) |=> $stable(cnt));

    // Clear forces the counter to zero.
    p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pulse |=> (cnt == '0));

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        // A newly enabled channel starts low.
        p_enable_waits_r9: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(en_q[i]) |-> !pwm_o[i]);

        // Outputs only rise right after a wrap.
        p_rise_on_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pwm_o[i]) |-> $past(wrap));
    end
endmodule

bind shared_pwm_timer shared_pwm_timer_chk #(.NCH(NCH), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .halt_q    (halt_q),
    .clr_pulse (clr_pulse),
    .tick      (tick),
    .wrap      (wrap),
    .cnt       (cnt),
    .en_q      (en_q),
    .pwm_o     (pwm_o)
);

// File: tb/sim_shared_pwm_timer.sv
// Bench for shared_pwm_timer: directed corner cases plus seeded random writes,
// checked every cycle against a requirement-level model.
module sim_shared_pwm_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  pwm_o;
    logic [15:0] count_o;

    int total = 0;
    int bad = 0;
    bit chk_on = 1'b0;
    bit finished = 1'b0;

    // Model state
    int  m_per_shd, m_per_act, m_cnt, m_pcnt, m_psc;
    int  m_cmp_shd [4];
    int  m_cmp_act [4];
    bit  m_halt;
    bit [3:0] m_en, m_out;

    always #2ns clk = ~clk;

    shared_pwm_timer u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pwm_o   (pwm_o),
        .count_o (count_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Model of the requirements, advanced at every rising edge.
    always @(posedge clk) begin
        bit clr, tk, wp;
        int nc, np;
        bit [3:0] no;
        if (!rst_n) begin
            m_per_shd = 20000; m_per_act = 20000; m_cnt = 0; m_pcnt = 0;
            m_psc = 0; m_halt = 0; m_en = '0; m_out = '0;
            for (int i = 0; i < 4; i++) begin m_cmp_shd[i] = 0; m_cmp_act[i] = 0; end
        end else begin
            clr = wr_en && (wr_addr == 3'd5) && wr_data[3];
            tk  = !m_halt && !clr && (m_pcnt >= m_psc);
            wp  = tk && (m_cnt + 1 >= m_per_act);
            nc  = clr ? 0 : (wp ? 0 : (tk ? m_cnt + 1 : m_cnt));
            np  = (clr || tk) ? 0 : (m_halt ? m_pcnt : m_pcnt + 1);
            for (int i = 0; i < 4; i++) begin
                if (!m_en[i])                              no[i] = 1'b0;
                else if (wp)                               no[i] = (m_cmp_shd[i] != 0);
                else if (tk && (nc == m_cmp_act[i]))       no[i] = 1'b0;
                else                                       no[i] = m_out[i];
            end
            if (wp) begin
                m_per_act = m_per_shd;
                for (int i = 0; i < 4; i++) m_cmp_act[i] = m_cmp_shd[i];
            end
            if (wr_en) begin
                case (wr_addr)
                    3'd0: m_per_shd = int'(wr_data);
                    3'd1, 3'd2, 3'd3, 3'd4: m_cmp_shd[int'(wr_addr) - 1] = int'(wr_data);
                    3'd5: begin m_halt = wr_data[2]; m_psc = int'(wr_data[11:5]); end
                    3'd6: m_en = wr_data[3:0];
                    default: ;
                endcase
            end
            m_cnt = nc; m_pcnt = np; m_out = no;
        end
    end

    // Every-cycle comparison against the model.
    always @(negedge clk) begin
        if (chk_on && !finished) begin
            chk(int'(count_o) == m_cnt, "R3 count", int'(count_o), m_cnt);
            chk(pwm_o == (m_out & m_en), "R5 outputs", int'(pwm_o), int'(m_out & m_en));
        end
    end

    task automatic wr(input int a, input int d);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_count(input int v);
        for (int k = 0; k < 30000; k++) begin
            if (int'(count_o) == v) return;
            @(negedge clk);
        end
        chk(1'b0, "R3 wait for count", int'(count_o), v);
    endtask

    task automatic measure(output int h [4]);
        for (int i = 0; i < 4; i++) h[i] = 0;
        for (int c = 0; c < 10; c++) begin
            for (int i = 0; i < 4; i++) h[i] += int'(pwm_o[i]);
            @(negedge clk);
        end
    endtask

    initial begin
        int h [4];
        int c0;
        bit [3:0] p0;
        void'($urandom(32'd9173));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        chk_on = 1'b1;
        // R1: reset state
        chk(count_o == 16'd0, "R1 count after reset", int'(count_o), 0);
        chk(pwm_o == 4'd0, "R1 outputs after reset", int'(pwm_o), 0);

        // R2: divide by 4 from a cleared counter gives count 2 after 8 clocks
        wr(5, (3 << 5) | 8);
        repeat (8) @(negedge clk);
        chk(count_o == 16'd2, "R2 prescaled count", int'(count_o), 2);

        // Short period and mixed compares; live values change at the long wrap
        wr(5, 8);
        wr(0, 10); wr(1, 0); wr(2, 10); wr(3, 15); wr(4, 4);
        wr(6, 15);
        wait_count(100);
        wait_count(0);
        measure(h);
        chk(h[0] == 0,  "R6 compare 0 stays low", h[0], 0);
        chk(h[1] == 10, "R6 compare equal period stays high", h[1], 10);
        chk(h[2] == 10, "R6 compare above period stays high", h[2], 10);
        chk(h[3] == 4,  "R5 compare 4 width", h[3], 4);

        // R4: new compare waits for the next wrap
        wr(4, 7);
        wait_count(5);
        chk(pwm_o[3] == 1'b0, "R4 old compare still live", int'(pwm_o[3]), 0);
        wait_count(0);
        wait_count(5);
        chk(pwm_o[3] == 1'b1, "R4 new compare live after wrap", int'(pwm_o[3]), 1);

        // R7: halt freezes count and outputs
        wr(5, 4);
        c0 = int'(count_o); p0 = pwm_o;
        repeat (6) @(negedge clk);
        chk(int'(count_o) == c0, "R7 halted count", int'(count_o), c0);
        chk(pwm_o == p0, "R7 halted outputs", int'(pwm_o), int'(p0));
        wr(5, 0);

        // R8: clear is a pulse
        wait_count(6);
        wr(5, 8);
        chk(count_o == 16'd0, "R8 cleared count", int'(count_o), 0);
        @(negedge clk);
        chk(count_o == 16'd1, "R8 counting resumes", int'(count_o), 1);

        // R9: disable drops at once, re-enable waits for wrap
        wr(6, 13);
        chk(pwm_o[1] == 1'b0, "R9 disabled low", int'(pwm_o[1]), 0);
        wait_count(3);
        wr(6, 15);
        chk(pwm_o[1] == 1'b0, "R9 enabled mid-period low", int'(pwm_o[1]), 0);
        wait_count(8);
        chk(pwm_o[1] == 1'b0, "R9 low until wrap", int'(pwm_o[1]), 0);
        wait_count(0);
        chk(pwm_o[1] == 1'b1, "R9 high after wrap", int'(pwm_o[1]), 1);

        // R10: unused address has no effect
        wr(7, 16'hFFFF);
        wait_count(0);
        measure(h);
        chk(h[0] == 0 && h[1] == 10 && h[2] == 10, "R10 widths unchanged", h[0] + h[1] + h[2], 20);
        chk(h[3] == 7, "R10 channel 3 width unchanged", h[3], 7);

        // Random writes with small periods and prescale
        for (int k = 0; k < 400; k++) begin
            int a, d;
            a = int'($urandom % 8);
            case (a)
                0: d = int'($urandom % 13);
                1, 2, 3, 4: d = int'($urandom % 16);
                5: d = (int'($urandom % 3) << 5) | (($urandom % 8 == 0) ? 4 : 0)
                       | (($urandom % 6 == 0) ? 8 : 0);
                6: d = int'($urandom % 16);
                default: d = int'($urandom % 65536);
            endcase
            wr(a, d);
            repeat (int'($urandom % 4)) @(negedge clk);
        end
        wr(5, 0);
        repeat (40) @(negedge clk);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #600us;
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog R3 actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule